// File: doc/BRIEF.md
# Cassette FSK Tone Generator

This block turns a serial transmit bit into a square-wave tone for recording on audio tape. A periodic tick, supplied as a clock enable, advances an 8-bit counter. The output level comes from that counter. A mark (logic one) selects the lowest counter bit. A space (logic zero) selects the bit just above it. With a 4800 Hz tick, the mark tone is 2400 Hz and the space tone is 1200 Hz, so the two tones are exactly an octave apart. The output is the inverse of the selected counter bit.

The block does not use the transmit bit directly. It keeps a latched line state, which is loaded whenever the incoming bit changes. A control-register write can also force that state to mark, so the tape carries the idle tone while the serializer is quiet. The same control write also latches a motor-enable bit, which the block brings out unchanged.

The tone output is a register that loads only on tick cycles. As a result, a change of line state between ticks never produces a short pulse.

Top module: `cas_tone_gen`

## Requirements
- R1: While reset is asserted and right after it is released, `tone_out` is 1 and `motor_on` is 0. The counter is zero and the line state is mark, so the first tick with a held mark drives `tone_out` to 0.
- R2: Each cycle with `tick` high advances the counter by exactly one. Cycles without `tick` leave the counter unchanged.
- R3: In the mark state, a tick loads `tone_out` with the inverse of bit 0 of the advanced count. This gives a square wave that toggles on every tick.
- R4: In the space state, a tick loads `tone_out` with the inverse of bit 1 of the advanced count. This gives a square wave that toggles on every second tick.
- R5: `tone_out` changes only on clock edges where `tick` is high, whatever `tx_bit` or the control port do in between.
- R6: When `tx_bit` differs from its value in the previous cycle, the line state takes the new value at that clock edge. A steady `tx_bit` leaves the line state alone.
- R7: A write (`ctrl_we` high) with `ctrl_data` bit 2 set forces the line state to mark. The force wins over a `tx_bit` change at the same edge. A tick at that same edge still uses the line state from before the edge.
- R8: Every write loads `motor_on` from `ctrl_data` bit 3, whether that bit is 0 or 1. `motor_on` holds its value between writes.
- R9: The counter is 8 bits wide and wraps from 255 to 0 with no other effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Tone clock enable, at twice the mark frequency |
| tx_bit | input | 1 | Serial transmit bit |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_data | input | 8 | Control write data: bit 2 forces mark, bit 3 is motor enable |
| tone_out | output | 1 | Square-wave tone level |
| motor_on | output | 1 | Latched motor enable |

## Verification
The line state and the counter are only visible through the tone. A wrong line state therefore shows up as the wrong half-period at the very next tick: the output toggles where it should hold, or holds where it should toggle. A counter that skips a step or misses one shifts the phase, and this is visible on the first tick that follows. A bad wrap, or a wrong force priority, needs a tick placed right after the event before it shows. For this reason the stimulus puts a tick directly after each count of 255, each forced write and each line change, and checks the output one edge later.

// File: rtl/cas_tone_gen.sv
module cas_tone_gen #(
  parameter int CNT_W     = 8,
  parameter int CTRL_W    = 8,
  parameter int MARK_BIT  = 0,
  parameter int FORCE_BIT = 2,
  parameter int MOTOR_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              tx_bit,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_data,
  output logic              tone_out,
  output logic              motor_on
);
  localparam int SPACE_BIT = MARK_BIT + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nx;
  logic             tx_q;
  logic             line_st;
  logic             force_mark;

  assign cnt_nx     = cnt + 1'b1;
  assign force_mark = ctrl_we && ctrl_data[FORCE_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      tone_out <= 1'b1;
    end else if (tick) begin
      cnt      <= cnt_nx;
      tone_out <= ~(line_st ? cnt_nx[MARK_BIT] : cnt_nx[SPACE_BIT]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q    <= 1'b1;
      line_st <= 1'b1;
    end else begin
      tx_q <= tx_bit;
      if (force_mark)
        line_st <= 1'b1;
      else if (tx_bit != tx_q)
        line_st <= tx_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      motor_on <= 1'b0;
    else if (ctrl_we)
      motor_on <= ctrl_data[MOTOR_BIT];
  end
endmodule

// File: rtl/cas_tone_gen_chk.sv
module cas_tone_gen_chk #(
  parameter int CNT_W     = 8,
  parameter int CTRL_W    = 8,
  parameter int FORCE_BIT = 2,
  parameter int MOTOR_BIT = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              tx_bit,
  input logic              ctrl_we,
  input logic [CTRL_W-1:0] ctrl_data,
  input logic              tone_out,
  input logic              motor_on,
  input logic [CNT_W-1:0]  cnt,
  input logic              tx_q,
  input logic              line_st
);
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == $past(cnt) + 1'b1);

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  // R5
  tone_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tone_out));

  // R3
  mark_tone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && line_st) |=> tone_out == !cnt[0]);

  // R4
  space_tone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !line_st) |=> tone_out == !cnt[1]);

  // R7
  force_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && ctrl_data[FORCE_BIT]) |=> line_st);

  // R6
  line_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_bit != tx_q) && !(ctrl_we && ctrl_data[FORCE_BIT])) |=> line_st == $past(tx_bit));

  // R8
  motor_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> motor_on == $past(ctrl_data[MOTOR_BIT]));

  // R8
  motor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(motor_on));
endmodule

bind cas_tone_gen cas_tone_gen_chk #(
  .CNT_W(CNT_W), .CTRL_W(CTRL_W), .FORCE_BIT(FORCE_BIT), .MOTOR_BIT(MOTOR_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .tx_bit(tx_bit),
  .ctrl_we(ctrl_we), .ctrl_data(ctrl_data), .tone_out(tone_out),
  .motor_on(motor_on), .cnt(cnt), .tx_q(tx_q), .line_st(line_st)
);

// File: tb/tb_cas_tone_gen.sv
module tb_cas_tone_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       tx_bit = 1'b1;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_data = 8'h00;
  logic       tone_out;
  logic       motor_on;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  cas_tone_gen dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tx_bit(tx_bit),
    .ctrl_we(ctrl_we), .ctrl_data(ctrl_data),
    .tone_out(tone_out), .motor_on(motor_on)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {tick, tx_bit, ctrl_we, ctrl_data[7:0], exp_tone, exp_motor}
  localparam logic [12:0] VEC [0:NVEC-1] = '{
    {1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0},  // R3 cnt 1
    {1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0},  // R3 cnt 2
    {1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0},  // R3 cnt 3
    {1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},  // R6 line to space, R5 hold
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0},  // R4 cnt 4
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0},  // R4 cnt 5
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},  // R4 cnt 6
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},  // R4 cnt 7
    {1'b0, 1'b0, 1'b1, 8'h04, 1'b0, 1'b0},  // R7 force mark
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0},  // R7 cnt 8 in mark
    {1'b0, 1'b0, 1'b1, 8'h08, 1'b1, 1'b1},  // R8 motor on
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1},  // R3 cnt 9
    {1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1},  // R6 change to 1
    {1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1},  // R6 change to 0, R5 hold
    {1'b1, 1'b0, 1'b1, 8'h0C, 1'b0, 1'b1},  // R7 tick uses old space, cnt 10
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1},  // R7 now mark, cnt 11
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1},  // R3 cnt 12
    {1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0}   // R8 motor off
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic tk, input logic tx, input logic we, input logic [7:0] d);
    tick = tk; tx_bit = tx; ctrl_we = we; ctrl_data = d;
    @(negedge clk);
    tick = 1'b0; ctrl_we = 1'b0; ctrl_data = 8'h00;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 tone in reset", tone_out, 1'b1);
    check("R1 motor in reset", motor_on, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 tone after release", tone_out, 1'b1);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9:2]);
      check($sformatf("R2-vec%0d tone", i), tone_out, VEC[i][1]);
      check($sformatf("R8-vec%0d motor", i), motor_on, VEC[i][0]);
    end

    // R9 wrap: counter is 12, mark state
    for (int i = 0; i < 243; i++) step(1'b1, 1'b1, 1'b0, 8'h00);
    check("R9 count 255 mark", tone_out, 1'b0);
    step(1'b0, 1'b0, 1'b0, 8'h00);
    check("R5 no tick hold", tone_out, 1'b0);
    step(1'b1, 1'b0, 1'b0, 8'h00);
    check("R9 wrap to 0 space", tone_out, 1'b1);
    step(1'b1, 1'b0, 1'b0, 8'h00);
    check("R4 count 1 space", tone_out, 1'b1);
    step(1'b1, 1'b0, 1'b0, 8'h00);
    check("R4 count 2 space", tone_out, 1'b0);

    // R1 mid-run reset
    step(1'b0, 1'b1, 1'b1, 8'h08);
    check("R8 motor set before reset", motor_on, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 tone on reset", tone_out, 1'b1);
    check("R1 motor on reset", motor_on, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    step(1'b1, 1'b1, 1'b0, 8'h00);
    check("R1 count restarts, mark", tone_out, 1'b0);
    step(1'b1, 1'b1, 1'b0, 8'h00);
    check("R2 count 2 mark", tone_out, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule